// File: doc/BRIEF.md
# Serial Slave Pause Controller

This block gives a serial memory slave its pause feature. The host pulls an active-low pause pin while the slave is selected, and the slave's shift logic must then stand still. Clock edges and input data are disregarded, so a half-received command or a partly filled write buffer survives the pause. The slave's data output is also released to high impedance. The block watches the chip select, serial clock, pause pin and a quad-mode flag. It decides in which system-clock cycle a pause begins and ends, and it hands the slave's shift logic gated strobes for rising and falling serial-clock edges.

The serial clock sets when a pause takes effect. A change on the pause pin takes effect at once when the serial clock is low. When the clock is high, the change waits for the next falling clock edge. A pulse that starts and ends while the clock stays high therefore causes no pause. In quad mode the pause pin carries data, so pausing is disabled. Deselecting the slave clears any pause and emits a one-cycle command-reset pulse.

Every pin is brought into the system clock domain through a synchroniser of `SYNC_STAGES` flops. Serial-clock edges are detected in that domain. A pin change reaches `hold_active_o` after `SYNC_STAGES + 1` system clocks, which is 3 with the default value.

Top module: `spi_pause_ctrl`

## Requirements
- R1: A pause can exist only while chip select is low; with `cs_n_i` high, `hold_active_o` stays 0 whatever `hold_n_i` does.
- R2: With chip select low and quad mode off, a low level on `hold_n_i` starts a pause. If `sck_i` is low, `hold_active_o` rises exactly `SYNC_STAGES + 1` system clocks after the pin change. If `sck_i` is high, the start waits until `sck_i` has fallen and then follows the same latency.
- R3: A return of `hold_n_i` to high ends the pause. If `sck_i` is low it ends immediately, with the same latency as R2. If `sck_i` is high, the end is deferred until `sck_i` falls.
- R4: While `hold_active_o` is 1, `so_oe_o` is 0 even when `so_oe_req_i` is 1.
- R5: While `hold_active_o` is 1, `sample_stb_o` and `launch_stb_o` stay 0 however `sck_i` toggles.
- R6: While `quad_en_i` is 1, no pause starts and any pause in progress ends; `hold_n_i` has no effect on any output.
- R7: A rising edge of chip select clears the pause, and `cmd_reset_o` then pulses high for exactly one system clock.
- R8: When the slave is selected and not paused, each rising `sck_i` edge gives exactly one `sample_stb_o` pulse and each falling edge gives exactly one `launch_stb_o` pulse. In this state `so_oe_o` follows `so_oe_req_i`.
- R9: During reset, every output is 0.
- R10: A low pulse on `hold_n_i` that begins and ends while `sck_i` is high, with no falling `sck_i` edge between, causes no pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| hold_n_i | input | 1 | Pause pin, active low |
| quad_en_i | input | 1 | Quad mode flag; 1 disables pausing |
| so_oe_req_i | input | 1 | Output-enable request from the slave's shift logic |
| hold_active_o | output | 1 | 1 while a pause is in force |
| sample_stb_o | output | 1 | One-cycle strobe on a usable rising serial-clock edge |
| launch_stb_o | output | 1 | One-cycle strobe on a usable falling serial-clock edge |
| so_oe_o | output | 1 | Final data-output enable |
| cmd_reset_o | output | 1 | One-cycle pulse on deselect, resets command state |

## Verification
Some rules can be checked on every cycle from the block's own signals, and the assertions cover these. The pause state may change only after a low serial-clock sample. Quad mode and deselection force the pause off on the next cycle. While paused, the output enable and both edge strobes stay low. The deferral itself can only be shown by the bench's scenarios. They show that a pin change made while the clock is high waits for the falling edge, that a high-clock glitch leaves no trace, and that the latency is exact. The one-to-one count of strobes against serial-clock edges, and the single command-reset pulse on deselect, are also shown there.

// File: rtl/spi_pause_pkg.sv
package spi_pause_pkg;

   // Synchronised view of the slave pins; order fixes the synchroniser bit lanes.
   typedef struct packed {
      logic quad;
      logic hold_n;
      logic sck;
      logic cs_n;
   } pins_t;

   localparam int unsigned PIN_W = $bits(pins_t);

   // Idle levels loaded into the synchroniser and edge flops at reset.
   localparam pins_t PINS_IDLE = '{quad: 1'b0, hold_n: 1'b1, sck: 1'b0, cs_n: 1'b1};

endpackage

// File: rtl/spi_pause_sync.sv
module spi_pause_sync #(
   parameter int unsigned WIDTH     = 4,
   parameter int unsigned STAGES    = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   initial begin
      assert (STAGES >= 2) else $error("spi_pause_sync: STAGES must be at least 2");
      assert (WIDTH >= 1) else $error("spi_pause_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_pause_edges.sv
module spi_pause_edges #(
   parameter int unsigned WIDTH        = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl_i;
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign rise_o[b] =  lvl_i[b] & ~prev_q[b];
      assign fall_o[b] = ~lvl_i[b] &  prev_q[b];
   end

endmodule

// File: rtl/spi_pause_hold_fsm.sv
module spi_pause_hold_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic sck_s,
   input  logic hold_n_s,
   input  logic quad_s,
   output logic held_o
);

   logic held_q;
   logic allow_hold;

   // Pausing is only meaningful while selected and with the pin not used as data.
   assign allow_hold = ~cs_n_s & ~quad_s;

   // A pin change commits only while the serial clock is low: immediately if it
   // already is, otherwise on the cycle the falling edge is seen.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          held_q <= 1'b0;
      else if (!allow_hold) held_q <= 1'b0;
      else if (!sck_s)     held_q <= ~hold_n_s;
   end

   assign held_o = held_q;

   AST_MOVE_ON_LOW_SCK: assert property (@(posedge clk) disable iff (!rst_n)
      ((held_q != $past(held_q)) && !$past(cs_n_s) && !$past(quad_s)) |-> !$past(sck_s)); // R2 R3

   AST_QUAD_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      quad_s |=> !held_q); // R6

   AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !held_q); // R1

endmodule

// File: rtl/spi_pause_ctrl.sv
module spi_pause_ctrl
   import spi_pause_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sck_i,
   input  logic hold_n_i,
   input  logic quad_en_i,
   input  logic so_oe_req_i,
   output logic hold_active_o,
   output logic sample_stb_o,
   output logic launch_stb_o,
   output logic so_oe_o,
   output logic cmd_reset_o
);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("spi_pause_ctrl: SYNC_STAGES must be at least 2");
   end

   pins_t pins_raw;
   pins_t pins_s;
   pins_t pins_rise;
   pins_t pins_fall;
   logic  held;
   logic  selected;

   assign pins_raw = '{quad: quad_en_i, hold_n: hold_n_i, sck: sck_i, cs_n: cs_n_i};

   spi_pause_sync #(
      .WIDTH   (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PINS_IDLE)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pins_raw),
      .sync_o  (pins_s)
   );

   spi_pause_edges #(
      .WIDTH   (PIN_W),
      .RST_VAL (PINS_IDLE)
   ) u_edges (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (pins_s),
      .rise_o (pins_rise),
      .fall_o (pins_fall)
   );

   spi_pause_hold_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_s   (pins_s.cs_n),
      .sck_s    (pins_s.sck),
      .hold_n_s (pins_s.hold_n),
      .quad_s   (pins_s.quad),
      .held_o   (held)
   );

   assign selected      = ~pins_s.cs_n;
   assign hold_active_o = held;
   assign sample_stb_o  = selected & ~held & pins_rise.sck;
   assign launch_stb_o  = selected & ~held & pins_fall.sck;
   assign so_oe_o       = selected & ~held & so_oe_req_i;
   assign cmd_reset_o   = pins_rise.cs_n;

   AST_OE_OFF_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active_o |-> !so_oe_o); // R4

   AST_NO_STROBE_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active_o |-> !(sample_stb_o || launch_stb_o)); // R5

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({sample_stb_o, launch_stb_o}) <= 1); // R8

   AST_RESET_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset_o |=> !cmd_reset_o); // R7

endmodule

// File: tb/spi_pause_ctrl_tb.sv
module spi_pause_ctrl_tb;

   localparam int unsigned STAGES = 2;
   localparam int unsigned LAT    = STAGES + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, quad = 1'b0, oe_req = 1'b0;
   logic hold_active, sample_stb, launch_stb, so_oe, cmd_reset;

   int checks = 0;
   int failures = 0;
   int n_sample = 0, n_launch = 0, n_creset = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   spi_pause_ctrl #(.SYNC_STAGES(STAGES)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cs_n_i        (cs_n),
      .sck_i         (sck),
      .hold_n_i      (hold_n),
      .quad_en_i     (quad),
      .so_oe_req_i   (oe_req),
      .hold_active_o (hold_active),
      .sample_stb_o  (sample_stb),
      .launch_stb_o  (launch_stb),
      .so_oe_o       (so_oe),
      .cmd_reset_o   (cmd_reset)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         if (sample_stb) n_sample <= n_sample + 1;
         if (launch_stb) n_launch <= n_launch + 1;
         if (cmd_reset)  n_creset <= n_creset + 1;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R9", "hold_active in reset", hold_active, 0);
      chk("R9", "outputs in reset", {sample_stb, launch_stb, so_oe, cmd_reset}, 0);
      rst_n = 1'b1;
      step(2);
   endtask

   task automatic t_idle_strobes();
      int s0, l0;
      cs_n = 1'b0; oe_req = 1'b1;
      step(6);
      s0 = n_sample; l0 = n_launch;
      for (int i = 0; i < 3; i++) begin
         sck = 1'b1; step(4);
         sck = 1'b0; step(4);
      end
      chk("R8", "sample strobes per rise", n_sample - s0, 3);
      chk("R8", "launch strobes per fall", n_launch - l0, 3);
      chk("R8", "oe follows request", so_oe, 1);
   endtask

   task automatic t_start_low();
      int s0, l0;
      hold_n = 1'b0;
      step(LAT - 1);
      chk("R2", "not yet held", hold_active, 0);
      step(1);
      chk("R2", "held after latency", hold_active, 1);
      chk("R4", "oe off while held", so_oe, 0);
      s0 = n_sample; l0 = n_launch;
      for (int i = 0; i < 4; i++) begin
         sck = 1'b1; step(4);
         sck = 1'b0; step(4);
      end
      chk("R5", "no sample strobes while held", n_sample - s0, 0);
      chk("R5", "no launch strobes while held", n_launch - l0, 0);
   endtask

   task automatic t_end_low();
      hold_n = 1'b1;
      step(LAT - 1);
      chk("R3", "still held before latency", hold_active, 1);
      step(1);
      chk("R3", "released after latency", hold_active, 0);
      chk("R8", "oe back after release", so_oe, 1);
   endtask

   task automatic t_defer();
      sck = 1'b1; step(4);
      hold_n = 1'b0; step(6);
      chk("R2", "start deferred while sck high", hold_active, 0);
      sck = 1'b0;
      step(LAT - 1);
      chk("R2", "not held before fall seen", hold_active, 0);
      step(1);
      chk("R2", "held after sck fall", hold_active, 1);
      sck = 1'b1; step(4);
      hold_n = 1'b1; step(6);
      chk("R3", "end deferred while sck high", hold_active, 1);
      sck = 1'b0;
      step(LAT);
      chk("R3", "released after sck fall", hold_active, 0);
   endtask

   task automatic t_glitch();
      sck = 1'b1; step(4);
      hold_n = 1'b0; step(4);
      hold_n = 1'b1; step(4);
      sck = 1'b0; step(6);
      chk("R10", "high-clock glitch ignored", hold_active, 0);
   endtask

   task automatic t_quad();
      quad = 1'b1; step(4);
      hold_n = 1'b0; step(6);
      chk("R6", "no pause in quad mode", hold_active, 0);
      chk("R6", "oe unaffected in quad mode", so_oe, 1);
      quad = 1'b0;
      step(LAT + 1);
      chk("R6", "pause once quad off", hold_active, 1);
      quad = 1'b1;
      step(LAT + 1);
      chk("R6", "quad ends pause", hold_active, 0);
      quad = 1'b0;
      step(LAT + 1);
   endtask

   task automatic t_deselect();
      int c0;
      chk("R7", "held before deselect", hold_active, 1);
      c0 = n_creset;
      cs_n = 1'b1;
      step(6);
      chk("R7", "deselect clears pause", hold_active, 0);
      chk("R7", "one command reset pulse", n_creset - c0, 1);
      chk("R1", "oe off when deselected", so_oe, 0);
      step(6);
      chk("R1", "no pause while deselected", hold_active, 0);
      hold_n = 1'b1; step(2);
      cs_n = 1'b0; step(6);
      chk("R1", "reselected with pin high", hold_active, 0);
   endtask

   initial begin
      step(3);
      t_reset();
      t_idle_strobes();
      t_start_low();
      t_end_low();
      t_defer();
      t_glitch();
      t_quad();
      t_deselect();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule